// File: doc/BRIEF.md
# Error Event Counter with Snapshot Reporting

This block accumulates single-cycle error event pulses in an internal counter and publishes the running total to a pair of holding bytes. The publication is called a transfer. Software can request a transfer by raising a request bit. Alternatively, the block transfers by itself on every pulse of an external once-per-second tick. The choice between the two is made by a report-mode bit.

Every transfer clears the internal counter so that a new counting round starts. An event that lands on the same cycle as a transfer is not lost; it becomes the first count of the new round.

Counting is gated by a two-bit select field, and only one value of that field enables it. When the counter wraps past its maximum, a sticky overflow flag is set. Software clears the flag with a one-cycle clear pulse. The flag drives an interrupt output through an enable bit.

Top module: `err_event_counter`

## Requirements
- R1: The internal counter is CNT_W = 16 bits wide. The holding register is presented as held_lo (count bits [7:0]) and held_hi (count bits [15:8]).
- R2: An err_pulse is counted only when cnt_sel equals 2'b01. With cnt_sel at 2'b00, 2'b10 or 2'b11, pulses do not change the count.
- R3: With auto_mode = 0, a 0-to-1 change of xfer_req copies the count into the holding register, visible on the cycle after the edge. While xfer_req stays at 1, no further transfer occurs.
- R4: With auto_mode = 1, every sec_tick pulse causes a transfer, and xfer_req has no effect.
- R5: A transfer resets the internal counter to 0. If an err_pulse that is enabled for counting occurs on the transfer cycle, the counter becomes 1 instead, so the event is counted in the next round.
- R6: Between transfers, held_lo and held_hi keep their value, whatever events arrive.
- R7: A counted event at count 16'hFFFF wraps the counter to 0 and sets ovf_flag. ovf_flag stays set until an ovf_clr pulse arrives. A set on the same cycle as a clear takes priority over the clear.
- R8: irq is 1 exactly when ovf_flag is 1 and ovf_ie is 1.
- R9: Reset (rst_n low) clears the counter, the holding register, ovf_flag and the request history, all to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_pulse | input | 1 | Single-cycle error event |
| sec_tick | input | 1 | Single-cycle one-second tick |
| cnt_sel | input | 2 | Counting select; 2'b01 enables counting |
| auto_mode | input | 1 | 0 selects manual transfer, 1 selects per-second transfer |
| xfer_req | input | 1 | Manual transfer request; a rising edge triggers a transfer |
| ovf_clr | input | 1 | Clears the overflow flag when pulsed |
| ovf_ie | input | 1 | Overflow interrupt enable |
| held_lo | output | 8 | Held count, low byte |
| held_hi | output | 8 | Held count, high byte |
| ovf_flag | output | 1 | Sticky overflow status |
| irq | output | 1 | Overflow interrupt |

## Verification
The internal counter can only be observed through the holding bytes. A wrong count, a missed restart or a dropped coincident event therefore appears at the ports on the cycle after the next transfer, as a mismatch with the number of pulses the bench has applied since the previous transfer. Sweeping the event count between transfers catches an off-by-one in either direction at once. A bad wrap or a lost overflow flag shows on ovf_flag and irq on the cycle after the 65536th counted event. A spurious retransfer shows as a changed held value while the request bit is held high.

// File: rtl/err_event_counter.sv
module err_event_counter #(
  parameter int CNT_W = 16,
  parameter logic [1:0] SEL_ON = 2'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_pulse,
  input  logic             sec_tick,
  input  logic [1:0]       cnt_sel,
  input  logic             auto_mode,
  input  logic             xfer_req,
  input  logic             ovf_clr,
  input  logic             ovf_ie,
  output logic [7:0]       held_lo,
  output logic [CNT_W-9:0] held_hi,
  output logic             ovf_flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q, held_q;
  logic req_q, ovf_q;

  wire ev   = err_pulse && (cnt_sel == SEL_ON);
  wire xfer = auto_mode ? sec_tick : (xfer_req && !req_q);
  wire wrap = ev && !xfer && (cnt_q == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= '0;
      req_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      req_q <= xfer_req;
      if (xfer) begin
        held_q <= cnt_q;
        cnt_q  <= ev ? CNT_W'(1) : '0;
      end else if (ev) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (wrap)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assign held_lo  = held_q[7:0];
  assign held_hi  = held_q[CNT_W-1:8];
  assign ovf_flag = ovf_q;
  assign irq      = ovf_q && ovf_ie;

  // R3
  manual_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && xfer_req && !req_q) |=> ({held_hi, held_lo} == $past(cnt_q)));
  // R3
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && req_q) |=> $stable({held_hi, held_lo}));
  // R4
  auto_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && sec_tick) |=> ({held_hi, held_lo} == $past(cnt_q)));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && !sec_tick) |=> $stable({held_hi, held_lo}));
  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && ev) |=> (cnt_q == CNT_W'(1)));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (cnt_q == '0));
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_ie |-> !irq);
endmodule

// File: tb/err_event_counter_tb.sv
module err_event_counter_tb_top;
  logic clk = 0, rst_n = 0;
  logic err_pulse = 0, sec_tick = 0, auto_mode = 0, xfer_req = 0, ovf_clr = 0, ovf_ie = 0;
  logic [1:0] cnt_sel = 2'b01;
  logic [7:0] held_lo, held_hi;
  logic ovf_flag, irq;
  int total = 0, bad = 0, cycles = 0;

  always #5 clk = ~clk;

  err_event_counter dut_i (.clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .sec_tick(sec_tick),
    .cnt_sel(cnt_sel), .auto_mode(auto_mode), .xfer_req(xfer_req), .ovf_clr(ovf_clr),
    .ovf_ie(ovf_ie), .held_lo(held_lo), .held_hi(held_hi), .ovf_flag(ovf_flag), .irq(irq));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic run(logic ev, logic rq, logic tk);
    err_pulse = ev; xfer_req = rq; sec_tick = tk;
    @(negedge clk);
  endtask

  task automatic events(int n);
    for (int i = 0; i < n; i++) run(1, 0, 0);
  endtask

  task automatic manual_xfer();
    run(0, 1, 0);
    run(0, 0, 0);
  endtask

  function automatic int held();
    return {held_hi, held_lo};
  endfunction

  initial begin
    @(negedge clk); @(negedge clk);
    // R9 reset state
    chk("R9 held", held(), 0);
    chk("R9 ovf", ovf_flag, 0);
    chk("R9 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 sweep of event counts between manual transfers
    for (int n = 0; n <= 20; n++) begin
      events(n);
      manual_xfer();
      chk("R3 manual sweep", held(), n);
    end

    // R3 level held high: no retransfer; R6 hold across events
    events(4);
    run(0, 1, 0);
    chk("R3 edge copy", held(), 4);
    for (int i = 0; i < 6; i++) run(1, 1, 0);
    chk("R3 no retransfer", held(), 4);
    chk("R6 hold", held(), 4);
    run(0, 0, 0);
    manual_xfer();
    chk("R5 no event lost", held(), 6);

    // R5 coincident event
    events(3);
    run(1, 1, 0);
    chk("R5 coincident held", held(), 3);
    run(0, 0, 0);
    manual_xfer();
    chk("R5 coincident counted", held(), 1);

    // R2 select field sweep
    for (int s = 0; s < 4; s++) begin
      cnt_sel = 2'(s);
      events(7);
      cnt_sel = 2'b01;
      manual_xfer();
      chk("R2 select", held(), (s == 1) ? 7 : 0);
    end

    // R1 byte split
    events(300);
    manual_xfer();
    chk("R1 low byte", held_lo, 300 % 256);
    chk("R1 high byte", held_hi, 300 / 256);

    // R4 auto mode
    auto_mode = 1;
    events(9);
    run(0, 1, 0); run(0, 0, 0); run(0, 1, 0);
    chk("R4 req ignored", held(), 300);
    run(0, 0, 1);
    chk("R4 tick copy", held(), 9);
    events(2);
    run(1, 0, 1);
    chk("R4 tick coincident", held(), 2);
    run(0, 0, 1);
    chk("R5 auto restart", held(), 1);
    run(0, 0, 0);
    auto_mode = 0;
    manual_xfer();

    // R7 overflow wrap
    events(65535);
    chk("R7 no ovf yet", ovf_flag, 0);
    run(1, 0, 0);
    chk("R7 ovf set", ovf_flag, 1);
    chk("R8 irq masked", irq, 0);
    ovf_ie = 1; #1;
    chk("R8 irq enabled", irq, 1);
    events(2);
    manual_xfer();
    chk("R7 wrapped count", held(), 2);
    chk("R7 sticky", ovf_flag, 1);
    @(negedge clk);
    ovf_clr = 1; run(0, 0, 0); ovf_clr = 0;
    chk("R7 cleared", ovf_flag, 0);
    chk("R8 irq low", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule